// File: doc/BRIEF.md
# Periodic Refresh Request Scheduler

This block decides when one SDRAM channel needs an automatic refresh. A free-running interval counter, clocked by the memory clock, measures a programmable number of cycles. Each time it completes an interval, the block adds one to a small backlog of owed refreshes. While that backlog is nonzero, the block holds a request toward the command arbiter. The request carries the set of chip selects that take part in refresh. Each grant retires one owed refresh, so an arbiter that is busy for several intervals still receives every refresh it owes, up to a fixed backlog limit.

Two controls shape the automatic refresh stream. A global switch halts everything: the counter freezes, the backlog is dropped and no request is shown. A per-chip-select skip mask removes unused chip selects from the request. When every chip select is skipped, the counter keeps running but no refresh is owed. A software-issued refresh is reported on a separate pulse input, which deliberately touches neither the counter nor the backlog.

Top module: `ref_sched`

## Requirements
- R1: After reset, and after every later reload, the backlog increases by one exactly `interval_i` enabled clock cycles after the counter started from zero. With a value of 10 and nothing else active, the backlog first reads 1 after the 10th clock edge following reset release.
- R2: The backlog saturates at 8. Further completed intervals leave it at 8.
- R3: `req_o` is high exactly when three conditions hold together: the backlog is nonzero, `refresh_off_i` is low, and at least one bit of `cs_skip_i` is 0.
- R4: On each clock edge where `req_o` and `grant_i` are both high, the backlog drops by one. If an interval completes on the same edge, the backlog is unchanged. A grant while `req_o` is low has no effect.
- R5: While `refresh_off_i` is 1, `req_o` is 0, the backlog is cleared on the next edge, and the interval counter holds its value.
- R6: When `refresh_off_i` returns to 0, counting resumes from the held counter value. No request appears until that interval completes.
- R7: `req_cs_o[i]` is 1 only when `req_o` is 1 and `cs_skip_i[i]` is 0. A skip bit of 1 excludes that chip select.
- R8: When all bits of `cs_skip_i` are 1, `req_o` is 0 and completed intervals do not add to the backlog. The interval counter keeps running, so the first interval completed after a chip select is unmasked lands on the original schedule.
- R9: A new `interval_i` value is captured only when the counter reloads. An interval already in progress finishes with the old value.
- R10: A pulse on `sw_refresh_i` changes neither the interval counter nor the backlog.
- R11: During and right after reset, `req_o` is 0, `req_cs_o` is 0 and `pend_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_i | input | CNT_W | Refresh interval in clock cycles, captured at each reload |
| refresh_off_i | input | 1 | 1 halts all automatic refresh |
| cs_skip_i | input | NUM_CS | 1 in bit i excludes chip select i from refresh |
| sw_refresh_i | input | 1 | Pulse marking a software-issued refresh (no effect on scheduling) |
| grant_i | input | 1 | Arbiter accepts the pending refresh on this edge |
| req_o | output | 1 | Automatic refresh requested |
| req_cs_o | output | NUM_CS | Chip selects to refresh with the current request |
| pend_o | output | PEND_W | Number of owed refreshes |

## Verification
On every cycle, the embedded assertions check the following:
- the backlog never exceeds its limit;
- a lone grant removes exactly one owed refresh;
- the halt switch both silences the request and clears the backlog;
- the halted counter does not move;
- an all-skipped mask never shows a request;
- a software pulse never alters the backlog.

Some behaviours depend on exact cycle positions across many intervals, and only the scoreboard scenarios can show them:
- the interval timing;
- a late reload of a changed interval;
- the resume from a held mid-interval count;
- a counter that kept running under a full mask.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

    // Action applied to the owed-refresh backlog on a clock edge
    typedef enum logic [1:0] {
        PEND_HOLD  = 2'd0,
        PEND_UP    = 2'd1,
        PEND_DOWN  = 2'd2,
        PEND_CLEAR = 2'd3
    } pend_op_e;

    // Halt wins; a simultaneous add and take cancel each other
    function automatic pend_op_e pick_pend_op(input logic halt,
                                              input logic add,
                                              input logic take);
        if (halt)
            return PEND_CLEAR;
        if (add && !take)
            return PEND_UP;
        if (take && !add)
            return PEND_DOWN;
        return PEND_HOLD;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [CNT_W-1:0] interval_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] lim_eff;

    // An interval of zero behaves as one cycle
    assign lim_eff = (lim_q == '0) ? CNT_W'(1) : lim_q;
    assign tick_o  = run_i && (cnt_q >= lim_eff - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= interval_i;
        end else if (run_i) begin
            if (tick_o) begin
                cnt_q <= '0;
                lim_q <= interval_i;   // new interval only at reload
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> $stable(cnt_q)); // R5

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q < lim_eff); // R9

endmodule

// File: rtl/ref_pend_ctr.sv
module ref_pend_ctr
    import ref_sched_pkg::*;
#(
    parameter int PEND_MAX = 8,
    parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              add_i,
    input  logic              take_i,
    output logic [PEND_W-1:0] pend_o
);
    localparam logic [PEND_W-1:0] CAP = PEND_W'(PEND_MAX);

    logic [PEND_W-1:0] pend_q;
    pend_op_e          op;

    assign op     = pick_pend_op(clear_i, add_i, take_i);
    assign pend_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            unique case (op)
                PEND_CLEAR: pend_q <= '0;
                PEND_UP:    if (pend_q < CAP)    pend_q <= pend_q + PEND_W'(1);
                PEND_DOWN:  if (pend_q != '0)    pend_q <= pend_q - PEND_W'(1);
                default:    pend_q <= pend_q;
            endcase
        end
    end

    AST_PEND_CAP: assert property (@(posedge clk) disable iff (rst)
        pend_q <= CAP); // R2

    AST_TAKE_DEC: assert property (@(posedge clk) disable iff (rst)
        (take_i && !add_i && !clear_i && pend_q != '0)
            |=> pend_q == $past(pend_q) - PEND_W'(1)); // R4

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> pend_q == '0); // R5

endmodule

// File: rtl/ref_sched.sv
module ref_sched #(
    parameter int CNT_W    = 16,
    parameter int NUM_CS   = 4,
    parameter int PEND_MAX = 8,
    parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  interval_i,
    input  logic              refresh_off_i,
    input  logic [NUM_CS-1:0] cs_skip_i,
    input  logic              sw_refresh_i,
    input  logic              grant_i,
    output logic              req_o,
    output logic [NUM_CS-1:0] req_cs_o,
    output logic [PEND_W-1:0] pend_o
);
    logic run;
    logic any_cs;
    logic tick;
    logic add;
    logic take;
    logic [PEND_W-1:0] pend;

    assign run    = !refresh_off_i;
    assign any_cs = !(&cs_skip_i);
    assign add    = tick && any_cs;
    assign req_o  = (pend != '0) && run && any_cs;
    assign take   = req_o && grant_i;
    assign pend_o = pend;

    ref_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .interval_i (interval_i),
        .tick_o     (tick)
    );

    ref_pend_ctr #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .clear_i (refresh_off_i),
        .add_i   (add),
        .take_i  (take),
        .pend_o  (pend)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign req_cs_o[i] = req_o && !cs_skip_i[i];
    end

    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        refresh_off_i |-> !req_o); // R5

    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (&cs_skip_i) |-> (!req_o && req_cs_o == '0)); // R8

    AST_SW_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        (sw_refresh_i && !tick && !take && run) |=> $stable(pend)); // R10

endmodule

// File: tb/sim_ref_sched.sv
`timescale 1ns/1ps
module sim_ref_sched;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         at;
        bit         req;
        int         pend;
        logic [3:0] cs;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] interval;
    logic        off;
    logic [3:0]  skip;
    logic        sw;
    logic        grant;
    logic        req;
    logic [3:0]  req_cs;
    logic [3:0]  pend;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ref_sched u0 (
        .clk           (clk),
        .rst           (rst),
        .interval_i    (interval),
        .refresh_off_i (off),
        .cs_skip_i     (skip),
        .sw_refresh_i  (sw),
        .grant_i       (grant),
        .req_o         (req),
        .req_cs_o      (req_cs),
        .pend_o        (pend)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic expect_at(input int at, input bit r, input int p,
                             input logic [3:0] c, input string tag);
        exp_t e;
        e.at = at; e.req = r; e.pend = p; e.cs = c; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic drive_at(input int n);
        while (cyc != n) @(negedge clk);
        #1;
    endtask

    // Monitor: pop and compare items at their cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at == cyc) begin
            exp_t e;
            e = sbq.pop_front();
            n_run++;
            if (req !== e.req || int'(pend) != e.pend || req_cs !== e.cs) begin
                n_fail++;
                $display("FAIL %s @%0d: req=%0d pend=%0d cs=%h expected req=%0d pend=%0d cs=%h",
                         e.tag, cyc, req, pend, req_cs, e.req, e.pend, e.cs);
            end
        end
    end

    initial begin
        rst = 1'b1; interval = 16'd10; off = 1'b0; skip = 4'h0;
        sw = 1'b0; grant = 1'b0;

        expect_at(0,   0, 0, 4'h0, "R11 reset state");
        expect_at(9,   0, 0, 4'h0, "R1 before first interval");
        expect_at(10,  1, 1, 4'hF, "R1 first interval");
        expect_at(20,  1, 2, 4'hF, "R1 second interval");
        expect_at(80,  1, 8, 4'hF, "R2 reach cap");
        expect_at(90,  1, 8, 4'hF, "R2 saturated");
        expect_at(100, 1, 8, 4'hF, "R2 still saturated");
        expect_at(101, 1, 7, 4'hF, "R4 first grant");
        expect_at(105, 1, 3, 4'hF, "R4 grants drain");
        expect_at(108, 0, 0, 4'h0, "R3 backlog empty");
        expect_at(109, 0, 0, 4'h0, "R4 grant without request");
        expect_at(110, 1, 1, 4'hF, "R1 schedule kept");
        expect_at(113, 1, 1, 4'hF, "R10 sw pulse no backlog change");
        expect_at(120, 1, 2, 4'hF, "R10 interval unchanged");
        expect_at(129, 1, 2, 4'hF, "R9 old interval runs out");
        expect_at(130, 1, 3, 4'hF, "R9 reload");
        expect_at(134, 1, 3, 4'hF, "R9 new interval not yet");
        expect_at(135, 1, 4, 4'hF, "R9 new interval used");
        expect_at(136, 1, 4, 4'hA, "R7 partial mask");
        expect_at(140, 1, 5, 4'hA, "R7 masked still counts");
        expect_at(141, 0, 5, 4'h0, "R8 all masked no request");
        expect_at(145, 0, 5, 4'h0, "R8 no backlog growth");
        expect_at(150, 0, 5, 4'h0, "R8 no backlog growth 2");
        expect_at(151, 1, 5, 4'hF, "R3 unmask shows request");
        expect_at(155, 1, 6, 4'hF, "R8 counter kept running");
        expect_at(158, 0, 0, 4'h0, "R5 halt clears");
        expect_at(165, 0, 0, 4'h0, "R5 halted");
        expect_at(172, 0, 0, 4'h0, "R6 no immediate request");
        expect_at(173, 1, 1, 4'hF, "R6 resume from held count");

        repeat (3) @(negedge clk);
        rst = 1'b0;

        drive_at(100); grant = 1'b1;
        drive_at(108); grant = 1'b0;
        drive_at(112); sw = 1'b1;
        drive_at(113); sw = 1'b0;
        drive_at(120); interval = 16'd5;
        drive_at(135); skip = 4'b0101;
        drive_at(140); skip = 4'hF;
        drive_at(150); skip = 4'h0;
        drive_at(157); off = 1'b1;
        drive_at(170); off = 1'b0;
        drive_at(180);

        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL R1 scoreboard: %0d items unchecked, expected 0", sbq.size());
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: cycle %0d, expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule